// File: doc/BRIEF.md
# Predicated Compare Unit with Predicate Register File

This block evaluates one relation between two integer operands and uses the result to update a small file of one-bit predicate registers. Each operation names a qualifying predicate and two destination predicates. The qualifier is read from the same file. A compare kind then decides how the two destinations are written. There are five kinds: a plain form, an unconditional form, and three parallel forms (and, or, and-or). The parallel forms let several compares feed one pair of predicates in the same schedule.

Relation code 4 turns the compare into a test-bit operation. It asks whether a selected bit of operand A is set. All five kinds apply to this relation as well. Two combinational read ports expose predicate values to the later instructions that consume them. A write lands at the clock edge, and a read in the same cycle still returns the value from before the edge.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset every predicate entry reads 0 except entry 0, which reads 1.
- R2: Entry 0 always reads 1, and any write aimed at it has no effect.
- R3: The relation code selects the test: 0 is A equal B, 1 is A not equal B, 2 is A less than B as signed values, and 3 is A less than B as unsigned values. Codes 5 to 7 evaluate as false.
- R4: Relation code 4 is a bit test. It is true when bit `op_b[5:0]` of A is 1.
- R5: Kind 0 (plain): with the qualifier true, the first target takes the relation and the second takes its complement. With the qualifier false, nothing changes.
- R6: Kind 1 (unconditional): both targets are always written. The first target takes qualifier AND relation, and the second takes qualifier AND NOT relation.
- R7: Kind 2 (and): with the qualifier true and the relation false, both targets become 0. Otherwise both are unchanged.
- R8: Kind 3 (or): with the qualifier true and the relation true, both targets become 1. Otherwise both are unchanged.
- R9: Kind 4 (and-or): with the qualifier true and the relation true, the first target becomes 1 and the second becomes 0. Otherwise both are unchanged. Kinds 5 to 7 write nothing.
- R10: When both destination indices name the same entry, the value for the second target is the one stored.
- R11: Updates take effect at the rising clock edge. A read in the cycle the operation is presented returns the old value. While `op_valid` is low, nothing changes.
- R12: The qualifier is the current stored value of entry `qual_idx`, read before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand; low 6 bits give the bit index for the bit test |
| rel_sel | input | 3 | Relation code |
| cmp_kind | input | 3 | Compare kind code |
| qual_idx | input | 6 | Qualifying predicate index |
| dst1_idx | input | 6 | First target index |
| dst2_idx | input | 6 | Second target index |
| rd_idx | input | 12 | Two packed read indices, port 0 in bits 5:0 |
| rd_val | output | 2 | Predicate values for the two read ports |

## Verification
The bench builds the block with its default parameters: 64-bit operands, 64 predicates and two read ports. With these values the full file can be swept through the read ports after every operation. The bench runs every relation code against every compare kind over a mixed operand set. That set covers equal values, sign-boundary values where the signed and unsigned orders disagree, and bit indices at 0 and 63. Its index patterns steer the qualifier onto entry 0 and onto stored predicates of both values. They also put targets on entry 0 and give both targets the same index, so every kind meets the qualifier-false, write-to-entry-0 and aliasing cases.

// File: rtl/predcmp_pkg.sv
package predcmp_pkg;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_LT  = 3'd2,
        REL_LTU = 3'd3,
        REL_BIT = 3'd4
    } rel_e;

    typedef enum logic [2:0] {
        CK_PLAIN = 3'd0,
        CK_UNC   = 3'd1,
        CK_AND   = 3'd2,
        CK_OR    = 3'd3,
        CK_ANDOR = 3'd4
    } ckind_e;

    // write request for the two targets of one compare
    typedef struct packed {
        logic we1;
        logic v1;
        logic we2;
        logic v2;
    } pwrite_t;

endpackage

// File: rtl/pred_relation.sv
module pred_relation #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [2:0]        sel,
    output logic              rel
);
    import predcmp_pkg::*;

    localparam int BIT_W = $clog2(DATA_W);

    logic [BIT_W-1:0] bit_pos;
    logic             eq_r;
    logic             lts_r;
    logic             ltu_r;

    assign bit_pos = b[BIT_W-1:0];

    always_comb begin
        eq_r  = (a == b);
        lts_r = ($signed(a) < $signed(b));
        ltu_r = (a < b);
        case (sel)
            REL_EQ:  rel = eq_r;
            REL_NE:  rel = !eq_r;
            REL_LT:  rel = lts_r;
            REL_LTU: rel = ltu_r;
            REL_BIT: rel = a[bit_pos];
            default: rel = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_update.sv
module pred_update (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic [2:0]            kind,
    input  logic                  qual,
    input  logic                  rel,
    output predcmp_pkg::pwrite_t  wr
);
    import predcmp_pkg::*;

    always_comb begin
        wr = '0;
        if (valid) begin
            case (kind)
                CK_PLAIN: begin
                    wr.we1 = qual;
                    wr.we2 = qual;
                    wr.v1  = rel;
                    wr.v2  = !rel;
                end
                CK_UNC: begin
                    wr.we1 = 1'b1;
                    wr.we2 = 1'b1;
                    wr.v1  = qual & rel;
                    wr.v2  = qual & !rel;
                end
                CK_AND: begin
                    wr.we1 = qual & !rel;
                    wr.we2 = qual & !rel;
                    wr.v1  = 1'b0;
                    wr.v2  = 1'b0;
                end
                CK_OR: begin
                    wr.we1 = qual & rel;
                    wr.we2 = qual & rel;
                    wr.v1  = 1'b1;
                    wr.v2  = 1'b1;
                end
                CK_ANDOR: begin
                    wr.we1 = qual & rel;
                    wr.we2 = qual & rel;
                    wr.v1  = 1'b1;
                    wr.v2  = 1'b0;
                end
                default: wr = '0;
            endcase
        end
    end

    AST_UNC_QFALSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == CK_UNC && !qual) |-> (wr.we1 && wr.we2 && !wr.v1 && !wr.v2)); // R6
    AST_PLAIN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == CK_PLAIN && qual) |-> (wr.we1 && wr.we2 && (wr.v1 != wr.v2))); // R5
    AST_PARALLEL_QFALSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind != CK_UNC && !qual) |-> (!wr.we1 && !wr.we2)); // R7
    AST_AND_RELFALSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == CK_AND && qual && !rel) |-> (wr.we1 && !wr.v1 && wr.we2 && !wr.v2)); // R7
    AST_ANDOR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == CK_ANDOR && qual && rel) |-> (wr.v1 && !wr.v2 && wr.we2)); // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!wr.we1 && !wr.we2)); // R11

endmodule

// File: rtl/pred_file.sv
module pred_file #(
    parameter int NPRED = 64,
    parameter int NREAD = 2,
    localparam int IDX_W = $clog2(NPRED)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  predcmp_pkg::pwrite_t   wr,
    input  logic [IDX_W-1:0]       d1,
    input  logic [IDX_W-1:0]       d2,
    input  logic [IDX_W-1:0]       qual_idx,
    output logic                   qual_val,
    input  logic [NREAD*IDX_W-1:0] rd_idx,
    output logic [NREAD-1:0]       rd_val
);

    typedef struct packed {
        logic [NPRED-1:0] bits;
    } pf_state_t;

    pf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr.we1) st_d.bits[d1] = wr.v1;
        // second target applied last so it wins on aliasing
        if (wr.we2) st_d.bits[d2] = wr.v2;
        st_d.bits[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= {{(NPRED-1){1'b0}}, 1'b1};
        else        st_q      <= st_d;
    end

    assign qual_val = st_q.bits[qual_idx];

    for (genvar g = 0; g < NREAD; g++) begin : g_rd
        assign rd_val[g] = st_q.bits[rd_idx[g*IDX_W +: IDX_W]];
    end

    AST_SECOND_TARGET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.we2 && d1 == d2 && d2 != '0) |=> (st_q.bits[$past(d2)] == $past(wr.v2))); // R10
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.we1 && !wr.we2) |=> (st_q.bits == $past(st_q.bits))); // R11
    AST_ENTRY0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.we1 && d1 == '0) |=> st_q.bits[0]); // R2

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
    parameter int DATA_W = 64,
    parameter int NPRED  = 64,
    parameter int NREAD  = 2,
    localparam int IDX_W = $clog2(NPRED)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [DATA_W-1:0]      op_a,
    input  logic [DATA_W-1:0]      op_b,
    input  logic [2:0]             rel_sel,
    input  logic [2:0]             cmp_kind,
    input  logic [IDX_W-1:0]       qual_idx,
    input  logic [IDX_W-1:0]       dst1_idx,
    input  logic [IDX_W-1:0]       dst2_idx,
    input  logic [NREAD*IDX_W-1:0] rd_idx,
    output logic [NREAD-1:0]       rd_val
);
    import predcmp_pkg::*;

    logic    rel;
    logic    qual;
    pwrite_t wr;

    pred_relation #(.DATA_W(DATA_W)) u_rel (
        .a   (op_a),
        .b   (op_b),
        .sel (rel_sel),
        .rel (rel)
    );

    pred_update u_upd (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (op_valid),
        .kind  (cmp_kind),
        .qual  (qual),
        .rel   (rel),
        .wr    (wr)
    );

    pred_file #(.NPRED(NPRED), .NREAD(NREAD)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .d1       (dst1_idx),
        .d2       (dst2_idx),
        .qual_idx (qual_idx),
        .qual_val (qual),
        .rd_idx   (rd_idx),
        .rd_val   (rd_val)
    );

    AST_OR_SETS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cmp_kind == CK_OR && qual && rel) |=> u_file.st_q.bits[$past(dst1_idx)]); // R8
    AST_EQ_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_sel == REL_EQ) |-> (rel == (op_a == op_b))); // R3

endmodule

// File: tb/pred_cmp_unit_test.sv
module pred_cmp_unit_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [2:0]  rel_sel = '0, cmp_kind = '0;
    logic [5:0]  qual_idx = '0, dst1_idx = '0, dst2_idx = '0;
    logic [11:0] rd_idx = '0;
    logic [1:0]  rd_val;

    int checks = 0;
    int failures = 0;
    logic [63:0] pm;

    pred_cmp_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .rel_sel(rel_sel), .cmp_kind(cmp_kind), .qual_idx(qual_idx),
        .dst1_idx(dst1_idx), .dst2_idx(dst2_idx), .rd_idx(rd_idx), .rd_val(rd_val)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic ref_rel(input logic [2:0] s, input logic [63:0] a, input logic [63:0] b);
        case (s)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) < $signed(b);
            3'd3: return a < b;
            3'd4: return a[b[5:0]];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] vec(input int i);
        case (i)
            0: return 64'd0;
            1: return 64'd5;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'd63;
            default: return 64'd7;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic read_all(input string tag);
        for (int e = 0; e < 64; e++) begin
            rd_idx = {6'(63 - e), 6'(e)};
            #1;
            chk(rd_val[0], pm[e], $sformatf("%s entry %0d", (e == 0) ? "R2" : tag, e));
            chk(rd_val[1], pm[63-e], $sformatf("%s entry %0d", (63 - e == 0) ? "R2" : tag, 63 - e));
        end
    endtask

    // model update from the requirements R5..R10, qualifier from stored state (R12)
    task automatic model(input logic [2:0] k, input logic q, input logic r,
                         input logic [5:0] a1, input logic [5:0] a2);
        case (k)
            3'd0: if (q) begin pm[a1] = r; pm[a2] = !r; end
            3'd1: begin pm[a1] = q & r; pm[a2] = q & !r; end
            3'd2: if (q && !r) begin pm[a1] = 1'b0; pm[a2] = 1'b0; end
            3'd3: if (q && r) begin pm[a1] = 1'b1; pm[a2] = 1'b1; end
            3'd4: if (q && r) begin pm[a1] = 1'b1; pm[a2] = 1'b0; end
            default: ;
        endcase
        pm[0] = 1'b1;
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n = 0;
        pm = 64'd1;
        #(CLK_P * 2 + 3);
        read_all("R1");
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 8; s++) begin
                for (int ai = 0; ai < 6; ai++) begin
                    for (int bi = 0; bi < 6; bi++) begin
                        logic q, r;
                        string ktag;
                        @(negedge clk);
                        n++;
                        op_a = vec(ai); op_b = vec(bi);
                        rel_sel = 3'(s); cmp_kind = 3'(k);
                        qual_idx = (n % 4 == 0) ? 6'd0 : 6'((n * 3 + 1) % 64);
                        dst1_idx = 6'((n * 7) % 64);
                        dst2_idx = (n % 9 == 0) ? dst1_idx : 6'((n * 13 + 5) % 64);
                        op_valid = 1'b1;
                        rd_idx = {dst2_idx, dst1_idx};
                        #1;
                        // same-cycle read returns old value
                        chk(rd_val[0], pm[dst1_idx], "R11 pre-edge read");
                        chk(rd_val[1], pm[dst2_idx], "R11 pre-edge read");
                        q = pm[qual_idx];
                        r = ref_rel(3'(s), op_a, op_b);
                        @(posedge clk);
                        #1;
                        op_valid = 1'b0;
                        model(3'(k), q, r, dst1_idx, dst2_idx);
                        case (k)
                            0: ktag = "R5/R12";
                            1: ktag = "R6";
                            2: ktag = "R7";
                            3: ktag = "R8";
                            default: ktag = "R9";
                        endcase
                        if (dst1_idx == dst2_idx && dst1_idx != 0) begin
                            rd_idx = {dst2_idx, dst1_idx};
                            #1;
                            chk(rd_val[1], pm[dst2_idx], "R10 aliased targets");
                        end
                        if ((n % 5) == 0 || dst1_idx == dst2_idx)
                            read_all($sformatf("%s %s", ktag, (s == 4) ? "R4" : "R3"));
                        else begin
                            rd_idx = {dst2_idx, dst1_idx};
                            #1;
                            chk(rd_val[0], pm[dst1_idx], $sformatf("%s %s t1", ktag, (s == 4) ? "R4" : "R3"));
                            chk(rd_val[1], pm[dst2_idx], $sformatf("%s %s t2", ktag, (s == 4) ? "R4" : "R3"));
                        end
                    end
                end
            end
        end
        // idle cycles with write-shaped inputs must change nothing
        @(negedge clk);
        cmp_kind = 3'd1; qual_idx = 6'd0; dst1_idx = 6'd9; dst2_idx = 6'd10; op_valid = 1'b0;
        @(posedge clk);
        #1;
        read_all("R11 idle");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule